// File: doc/BRIEF.md
# Multi-Mode Alignment Pulse Generator

This block makes a slow alignment strobe that is locked to a fast input clock. It runs in one of three modes. In continuous mode a free-running divided clock reaches the output only while a request is present. In burst mode a rising request edge starts a counted train of pulses. In repeat mode the external request pin is reclocked and passed to the output. The divided clock comes from a prescaler (divide by 1, 2 or 4) and a main divider (2 to 4095). Together they give total ratios from 2 up to 16380.

A separate path select chooses what drives the output: the internal generator or the reclocked request. Generator modes are meant to run with the generator path, and repeat mode with the request path. Mode, path select and divider settings are held in shadow registers. These are loaded only at reset or at the main divider's terminal count, so a change never produces a shortened pulse. Gating in continuous mode never stops or restarts the divider, so the pulse phase survives any number of gate cycles.

Top module: `align_pulse_gen`

## Requirements
- R1: While reset is low and in the cycle after it, alignOut and busy are 0.
- R2: On the generator path with a request present, alignOut has a period of P*N clocks and is high for P*floor(N/2) of them. P comes from preSel: 0 gives 1, 1 gives 2, and 2 or 3 give 4. N is divCount, and any value below 2 acts as 2.
- R3: In continuous mode (modeSel=0) pulses appear only while reqPin OR reqReg is high. The gate is sampled once per divider period, and with both requests low alignOut stays 0.
- R4: Gating never moves the divider phase. After the gate is reopened, every rising edge of alignOut lies a whole number of periods after a rising edge seen before the gate closed.
- R5: In burst mode (modeSel=1) a rising edge on the synchronized reqPin produces exactly burstLen+1 pulses. Each pulse starts on a period boundary and is high for the full P*floor(N/2) clocks.
- R6: A rising request edge while a burst is pending or running is ignored. A new edge after busy has fallen starts a fresh burst.
- R7: busy rises within four clocks of the request edge and is still 1 when the last pulse of the burst falls. It is 0 once the burst's final period ends.
- R8: In repeat mode with bypassSel=1, alignOut equals reqPin delayed by exactly three clocks: two synchronizer stages and one output register.
- R9: bypassSel=1 routes the reclocked request to alignOut and hides the divider. bypassSel=0 routes the generator, which gives 0 in repeat mode.
- R10: modeSel, bypassSel, preSel and divCount take effect only at reset or at the divider terminal count. Every high and low run of alignOut has either the old or the new length, never a shortened one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqPin | input | 1 | Asynchronous request pin |
| reqReg | input | 1 | Register-driven request bit (continuous gate only) |
| modeSel | input | 2 | 0 continuous, 1 burst, 2 repeat, 3 off |
| preSel | input | 2 | Prescaler select: 0 gives 1, 1 gives 2, 2 or 3 give 4 |
| divCount | input | DIV_W | Main divider ratio, 2 to 4095 |
| burstLen | input | BURST_W | Burst size minus one |
| bypassSel | input | 1 | 1 selects reclocked request, 0 selects generator |
| alignOut | output | 1 | Alignment pulse output (registered) |
| busy | output | 1 | Burst pending or in progress |

## Verification
The request pin reaches alignOut three clocks after it is driven, and the repeat test samples exactly at the second and third falling edges after each pin change. busy appears three clocks after a request edge, and the burst tests read it at the fifth falling edge. A configuration change waits at most one old period, so each test allows sixty clocks before it measures. Periods, duty and burst counts are taken as run lengths sampled once per falling edge, which makes them independent of the absolute phase.

// File: rtl/align_pulse_pkg.sv
package align_pulse_pkg;

  typedef enum logic [1:0] {
    MODE_CONT   = 2'd0,
    MODE_BURST  = 2'd1,
    MODE_REPEAT = 2'd2,
    MODE_OFF    = 2'd3
  } pulseMode_t;

  // strobes from datapath to control
  typedef struct packed {
    logic tc;         // divider terminal count this cycle
    logic phaseHigh;  // divided clock high phase
    logic reqRise;    // synchronized request rising edge
    logic reqLevel;   // synchronized request level
  } divEvt_t;

  // live shadow configuration
  typedef struct packed {
    pulseMode_t mode;
    logic       bypass;
  } cfgView_t;

endpackage

// File: rtl/align_pulse_dp.sv
module align_pulse_dp
  import align_pulse_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqPin,
  input  logic [1:0]       preSel,
  input  logic [DIV_W-1:0] divCount,
  output divEvt_t          evt
);
  localparam int PRE_W = 3;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   reqPrev;
  logic [PRE_W-1:0]       preNext, preSh, preCnt;
  logic [DIV_W-1:0]       divNext, divSh, mainCnt;
  logic                   tick, termCnt;

  // request synchronizer, one flop per stage
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncChain[s] <= 1'b0;
      else if (s == 0) syncChain[s] <= reqPin;
      else syncChain[s] <= syncChain[(s > 0) ? s - 1 : 0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) reqPrev <= 1'b0;
    else reqPrev <= syncChain[SYNC_STAGES-1];
  end

  always_comb begin
    case (preSel)
      2'd0:    preNext = PRE_W'(1);
      2'd1:    preNext = PRE_W'(2);
      default: preNext = PRE_W'(4);
    endcase
    divNext = (divCount < DIV_W'(2)) ? DIV_W'(2) : divCount;
  end

  assign tick    = (preCnt == preSh - PRE_W'(1));
  assign termCnt = tick && (mainCnt == divSh - DIV_W'(1));

  // shadows load at reset and terminal count; reset parks counters on terminal count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preSh   <= preNext;
      divSh   <= divNext;
      preCnt  <= preNext - PRE_W'(1);
      mainCnt <= divNext - DIV_W'(1);
    end else if (termCnt) begin
      preSh   <= preNext;
      divSh   <= divNext;
      preCnt  <= '0;
      mainCnt <= '0;
    end else if (tick) begin
      preCnt  <= '0;
      mainCnt <= mainCnt + DIV_W'(1);
    end else begin
      preCnt  <= preCnt + PRE_W'(1);
    end
  end

  assign evt.tc        = termCnt;
  assign evt.phaseHigh = (mainCnt < (divSh >> 1));
  assign evt.reqLevel  = syncChain[SYNC_STAGES-1];
  assign evt.reqRise   = syncChain[SYNC_STAGES-1] && !reqPrev;

endmodule

// File: rtl/align_pulse_ctrl.sv
module align_pulse_ctrl
  import align_pulse_pkg::*;
#(
  parameter int BURST_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  divEvt_t            evt,
  input  logic               reqReg,
  input  logic [1:0]         modeSel,
  input  logic               bypassSel,
  input  logic [BURST_W-1:0] burstLen,
  output logic               alignOut,
  output logic               busy,
  output cfgView_t           cfg
);
  pulseMode_t         modeSh;
  logic               bypSh, gateEn, armed, active, genSig, startArm;
  logic [BURST_W-1:0] remain;

  assign startArm = (modeSh == MODE_BURST) && evt.reqRise && !armed && !active;

  always_comb begin
    case (modeSh)
      MODE_CONT:  genSig = gateEn && evt.phaseHigh;
      MODE_BURST: genSig = active && evt.phaseHigh;
      default:    genSig = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeSh   <= pulseMode_t'(modeSel);
      bypSh    <= bypassSel;
      gateEn   <= 1'b0;
      armed    <= 1'b0;
      active   <= 1'b0;
      remain   <= '0;
      alignOut <= 1'b0;
    end else begin
      if (evt.tc) begin
        modeSh <= pulseMode_t'(modeSel);
        bypSh  <= bypassSel;
        gateEn <= evt.reqLevel || reqReg;
      end
      if (startArm) armed <= 1'b1;
      else if (evt.tc && armed) armed <= 1'b0;
      if (evt.tc && armed) begin
        active <= 1'b1;
        remain <= burstLen;
      end else if (evt.tc && active) begin
        if (remain == '0) active <= 1'b0;
        else remain <= remain - BURST_W'(1);
      end
      alignOut <= bypSh ? evt.reqLevel : genSig;
    end
  end

  assign busy       = armed || active;
  assign cfg.mode   = modeSh;
  assign cfg.bypass = bypSh;

endmodule

// File: rtl/align_pulse_gen.sv
module align_pulse_gen
  import align_pulse_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int BURST_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqPin,
  input  logic               reqReg,
  input  logic [1:0]         modeSel,
  input  logic [1:0]         preSel,
  input  logic [DIV_W-1:0]   divCount,
  input  logic [BURST_W-1:0] burstLen,
  input  logic               bypassSel,
  output logic               alignOut,
  output logic               busy
);
  divEvt_t  evt;
  cfgView_t cfg;

  align_pulse_dp #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .reqPin(reqPin), .preSel(preSel),
    .divCount(divCount), .evt(evt)
  );

  align_pulse_ctrl #(.BURST_W(BURST_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .reqReg(reqReg), .modeSel(modeSel),
    .bypassSel(bypassSel), .burstLen(burstLen), .alignOut(alignOut),
    .busy(busy), .cfg(cfg)
  );

endmodule

// File: rtl/align_pulse_chk.sv
module align_pulse_chk
  import align_pulse_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     alignOut,
  input logic     busy,
  input divEvt_t  evt,
  input cfgView_t cfg
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!alignOut && !busy));

  assert_rise_from_phase_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $rose(alignOut) && !$past(cfg.bypass)) |-> $past(evt.phaseHigh));

  assert_busy_from_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $rose(busy)) |-> $past(evt.reqRise));

  assert_busy_ends_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $fell(busy)) |-> !alignOut);

  assert_repeat_follow_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cfg.bypass)) |-> (alignOut == $past(evt.reqLevel)));

  assert_repeat_gen_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mode == MODE_REPEAT && !cfg.bypass) |=> !alignOut);

  assert_no_runt_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $rose(alignOut) && !$past(cfg.bypass)) |-> $past(evt.tc, 2));

endmodule

bind align_pulse_gen align_pulse_chk i_chk (
  .clk(clk), .rstN(rstN), .alignOut(alignOut), .busy(busy),
  .evt(evt), .cfg(cfg)
);

// File: tb/test_align_pulse_gen.sv
`timescale 1ns/1ps
module test_align_pulse_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqPin = 1'b0;
  logic        reqReg = 1'b0;
  logic [1:0]  modeSel = 2'd0;
  logic [1:0]  preSel = 2'd0;
  logic [11:0] divCount = 12'd10;
  logic [3:0]  burstLen = 4'd0;
  logic        bypassSel = 1'b0;
  logic        alignOut, busy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  align_pulse_gen i_align_pulse_gen (
    .clk(clk), .rstN(rstN), .reqPin(reqPin), .reqReg(reqReg),
    .modeSel(modeSel), .preSel(preSel), .divCount(divCount),
    .burstLen(burstLen), .bypassSel(bypassSel),
    .alignOut(alignOut), .busy(busy)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      fails = fails + 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setCfg(input logic [1:0] m, input logic [1:0] p, input int n,
                        input int b, input logic byp);
    @(negedge clk);
    modeSel = m; preSel = p; divCount = 12'(n); burstLen = 4'(b); bypassSel = byp;
    idle(60);
  endtask

  task automatic waitLevel(input logic lvl);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (alignOut == lvl) return;
    end
  endtask

  task automatic measure(output int hi, output int lo);
    waitLevel(1'b0);
    waitLevel(1'b1);
    hi = 0; lo = 0;
    while (alignOut && hi < 9000) begin hi++; @(negedge clk); end
    while (!alignOut && lo < 9000) begin lo++; @(negedge clk); end
  endtask

  task automatic countHigh(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (alignOut) highs++;
    end
  endtask

  // R1
  task automatic testReset();
    @(negedge clk);
    check(alignOut == 1'b0, "R1 alignOut in reset", alignOut, 0);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(alignOut == 1'b0, "R1 alignOut after reset", alignOut, 0);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
  endtask

  // R2
  task automatic divCase(input logic [1:0] p, input int n, input int expHi, input int expLo);
    int hi, lo;
    reqReg = 1'b1;
    setCfg(2'd0, p, n, 0, 1'b0);
    measure(hi, lo);
    check(hi == expHi, "R2 high time", hi, expHi);
    check(lo == expLo, "R2 low time", lo, expLo);
  endtask

  // R3, R4
  task automatic testGate();
    int c0, c1, highs, hi, lo;
    reqReg = 1'b1; reqPin = 1'b0;
    setCfg(2'd0, 2'd0, 10, 0, 1'b0);
    waitLevel(1'b0); waitLevel(1'b1);
    c0 = cyc;
    reqReg = 1'b0;
    idle(15);
    countHigh(40, highs);
    check(highs == 0, "R3 masked with no request", highs, 0);
    reqPin = 1'b1;
    waitLevel(1'b1);
    c1 = cyc;
    check(((c1 - c0) % 10) == 0, "R4 phase kept across gating", (c1 - c0) % 10, 0);
    measure(hi, lo);
    check(hi == 5 && lo == 5, "R3 pin request opens gate", hi * 100 + lo, 505);
    reqPin = 1'b0;
  endtask

  // R10
  task automatic testRunt();
    int run, bad, trans, hi, lo;
    logic prev;
    reqReg = 1'b1;
    setCfg(2'd0, 2'd0, 10, 0, 1'b0);
    waitLevel(1'b0); waitLevel(1'b1);
    idle(2);
    divCount = 12'd4;
    waitLevel(1'b0);
    prev = 1'b0; run = 1; bad = 0; trans = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (alignOut != prev) begin
        trans++;
        if (run != 5 && run != 2) bad++;
        run = 1;
      end else run++;
      prev = alignOut;
    end
    check(bad == 0, "R10 no shortened run", bad, 0);
    check(trans >= 10, "R10 pulses continue", trans, 10);
    measure(hi, lo);
    check(hi == 2 && lo == 2, "R10 new ratio in effect", hi * 100 + lo, 202);
  endtask

  // R5, R6, R7
  task automatic burstRun(input int len, input int retrig, input int window, input int expPulses);
    int rises, bad, hi;
    logic prev, busyEarly, busyAtFall;
    rises = 0; bad = 0; hi = 0; busyEarly = 0; busyAtFall = 0;
    prev = alignOut;
    burstLen = 4'(len);
    for (int i = 0; i < window; i++) begin
      if (i == 0) reqPin = 1'b1;
      if (i == 3) reqPin = 1'b0;
      if (i == retrig) reqPin = 1'b1;
      if (i == retrig + 3) reqPin = 1'b0;
      @(negedge clk);
      if (i == 4) busyEarly = busy;
      if (alignOut && !prev) rises++;
      if (alignOut) hi++;
      if (!alignOut && prev) begin
        if (hi != 2) bad++;
        busyAtFall = busy;
        hi = 0;
      end
      prev = alignOut;
    end
    if (retrig >= 0)
      check(rises == expPulses, "R6 retrigger during burst ignored", rises, expPulses);
    else
      check(rises == expPulses, "R5 burst pulse count", rises, expPulses);
    check(bad == 0, "R5 full high time per pulse", bad, 0);
    check(busyEarly == 1'b1, "R7 busy after trigger", busyEarly, 1);
    check(busyAtFall == 1'b1, "R7 busy at last pulse fall", busyAtFall, 1);
    check(busy == 1'b0, "R7 busy clear after burst", busy, 0);
  endtask

  task automatic testBurst();
    reqReg = 1'b0; reqPin = 1'b0;
    setCfg(2'd1, 2'd0, 4, 0, 1'b0);
    burstRun(2, -10, 120, 3);
    burstRun(0, -10, 120, 1);
    burstRun(15, -10, 120, 16);
    burstRun(7, 12, 120, 8);
    burstRun(1, -10, 120, 2);
  endtask

  // R8
  task automatic testRepeat();
    reqPin = 1'b0; reqReg = 1'b0;
    setCfg(2'd2, 2'd0, 2, 0, 1'b1);
    @(negedge clk); reqPin = 1'b1;
    @(negedge clk); check(alignOut == 1'b0, "R8 rise not early (1)", alignOut, 0);
    @(negedge clk); check(alignOut == 1'b0, "R8 rise not early (2)", alignOut, 0);
    @(negedge clk); check(alignOut == 1'b1, "R8 rise at three clocks", alignOut, 1);
    reqPin = 1'b0;
    idle(2);
    check(alignOut == 1'b1, "R8 fall not early", alignOut, 1);
    @(negedge clk); check(alignOut == 1'b0, "R8 fall at three clocks", alignOut, 0);
  endtask

  // R9
  task automatic testBypass();
    int highs;
    reqPin = 1'b0; reqReg = 1'b1;
    setCfg(2'd0, 2'd0, 2, 0, 1'b1);
    countHigh(40, highs);
    check(highs == 0, "R9 bypass hides divider", highs, 0);
    reqPin = 1'b1;
    idle(3);
    check(alignOut == 1'b1, "R9 bypass follows request", alignOut, 1);
    reqReg = 1'b0;
    setCfg(2'd2, 2'd0, 2, 0, 1'b0);
    countHigh(40, highs);
    check(highs == 0, "R9 repeat mode on generator path is low", highs, 0);
    reqPin = 1'b0;
  endtask

  initial begin
    testReset();
    divCase(2'd0, 10, 5, 5);
    divCase(2'd1, 7, 6, 8);
    divCase(2'd3, 3, 4, 8);
    divCase(2'd2, 2, 4, 4);
    divCase(2'd0, 0, 1, 1);
    testGate();
    testRunt();
    testBurst();
    testRepeat();
    testBypass();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule